// File: doc/BRIEF.md
# SD Card Command Sequencer

This block runs one SD card command at a time for a host controller. Software writes a 32-bit argument, then a 16-bit command word that carries a 6-bit command index and a few flags. Setting the start bit of that word opens a request on a card-side valid/ready handshake. The block then waits for the card's reply. The reply carries a length in bytes, 128 bits of payload and an error indication.

The block sorts each reply into one of three cases: no response, a short 32-bit response, or a long 128-bit response. It checks the reply length against the class of response the command asked for. A reply that passes the check is stored in four 32-bit response words. A long reply is stored with its words in reversed order. A failed command sets a fail flag in the command word and a timeout bit in the status word. A command flagged as busy-wait can raise a busy-completion status bit instead.

CRC work, CMD-line bit timing and the card itself sit outside this block.

Top module: `sdc_cmd_issuer`

## Requirements
- R1: After reset, `busy`, `req_valid` and `resp_ready` are low, and `cmd_reg`, `arg_reg`, `host_status` and `rsp_words` are all zero.
- R2: A command write with bit 15 set while idle raises `busy` on the next cycle. It also raises `req_valid`, with `req_index` equal to bits 5:0 of the written word and `req_arg` equal to the stored argument. `req_valid` and both fields hold until the cycle in which `req_ready` is high.
- R3: A command write with bit 15 clear only stores the word. No request is made.
- R4: Once the request has been accepted, `resp_ready` is high. The reply is taken in the cycle when `resp_valid` is high. On the next cycle `busy` is low and bit 15 of `cmd_reg` reads 0.
- R5: A 4-byte reply to a command whose long flag (bit 9) is clear stores `resp_data[127:96]` (payload bytes 0 to 3, big-endian) in word 0, which is `rsp_words[31:0]`. Words 1 to 3 become zero.
- R6: A 16-byte reply stores `resp_data[32k+31:32k]` in word k. Word 0 therefore holds payload bytes 12 to 15, and word 3 holds bytes 0 to 3.
- R7: When a response is expected (bit 10 clear), the command fails in any of these cases: `resp_err` is high, the length is 0, the length is 4 with bit 9 set, or the length is anything other than 4 or 16. A failure sets `cmd_reg` bit 14 and `host_status` bit 6 and leaves `rsp_words` unchanged.
- R8: With the no-response flag (bit 10) set, any reply length is accepted and `rsp_words` stays unchanged. A high `resp_err` still fails the command.
- R9: A command that completes without failure, with the busy-wait flag (bit 11) set and `cfg_busy_irq_en` high, sets `host_status` bit 10. Without the enable, bit 10 is not set.
- R10: When `sts_clr_en` is high, each `host_status` bit that is set in `sts_clr_mask` is cleared. A status bit being set in the same cycle wins over the clear.
- R11: While `busy` is high, writes to the command and argument registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 16 | Command word to write |
| arg_wr_en | input | 1 | Argument register write strobe |
| arg_wr_data | input | 32 | Argument to write |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 16 | Write-one-to-clear mask for the status word |
| cfg_busy_irq_en | input | 1 | Enables the busy-completion status bit |
| cmd_reg | output | 16 | Command register readback |
| arg_reg | output | 32 | Argument register readback |
| host_status | output | 16 | Status word (bit 6 timeout, bit 10 busy done) |
| busy | output | 1 | High while a command is in flight |
| rsp_words | output | 128 | Response words; word k is at [32k+31:32k] |
| req_valid | output | 1 | Card request valid |
| req_ready | input | 1 | Card accepts the request |
| req_index | output | 6 | Command index sent to the card |
| req_arg | output | 32 | Argument sent to the card |
| resp_ready | output | 1 | Block is waiting for the card's reply |
| resp_valid | input | 1 | Card reply is present |
| resp_err | input | 1 | Card reports that the command failed |
| resp_len | input | 5 | Reply length in bytes |
| resp_data | input | 128 | Reply payload; byte 0 is at [127:120] |

## Verification
The assertions check on every cycle the properties that hold in every state:
- a held request keeps its fields stable;
- the request and reply phases never overlap;
- a start or a completion moves `busy` and the start bit as expected;
- writes made while busy leave the command and argument unchanged;
- a card error always sets the fail bits;
- a no-response completion never alters the response words.

Only the bench's scenarios can show that the stored data is correct: the byte order of short and long replies, and the rejection of each bad length. They also show that the busy-wait bit depends on the configuration enable, and that status clears interact correctly with new completions. The behavioural model compares every output on each clock through those scenarios.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int IDX_W     = 6;
    localparam int WORD_W    = 32;
    localparam int RSP_WORDS = 4;
    localparam int RSP_W     = WORD_W * RSP_WORDS;
    localparam int LEN_W     = 5;
    localparam int CMD_W     = 16;
    localparam int STS_W     = 16;

    localparam int SHORT_BYTES = WORD_W / 8;
    localparam int LONG_BYTES  = RSP_W / 8;

    // command word bit positions
    localparam int CB_LONG  = 9;
    localparam int CB_NORSP = 10;
    localparam int CB_BWAIT = 11;
    localparam int CB_FAIL  = 14;
    localparam int CB_START = 15;

    // status word bit positions
    localparam int SB_TIMEOUT = 6;
    localparam int SB_BUSYDONE = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        CAP_NONE  = 2'd0,
        CAP_SHORT = 2'd1,
        CAP_LONG  = 2'd2
    } cap_e;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             long_rsp;
        logic             no_rsp;
        logic             busy_wait;
    } cmd_fields_t;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output cmd_fields_t      fields
);

    always_comb begin
        fields.index     = cmd_word[IDX_W-1:0];
        fields.long_rsp  = cmd_word[CB_LONG];
        fields.no_rsp    = cmd_word[CB_NORSP];
        fields.busy_wait = cmd_word[CB_BWAIT];
    end

endmodule

// File: rtl/sdc_resp_judge.sv
module sdc_resp_judge
    import sdc_pkg::*;
(
    input  logic             want_long,
    input  logic             want_none,
    input  logic             card_err,
    input  logic [LEN_W-1:0] len_bytes,
    output logic             ok,
    output cap_e             cap
);

    always_comb begin
        ok  = 1'b0;
        cap = CAP_NONE;
        if (card_err) begin
            ok = 1'b0;
        end else if (want_none) begin
            ok = 1'b1;
        end else if (len_bytes == LEN_W'(LONG_BYTES)) begin
            ok  = 1'b1;
            cap = CAP_LONG;
        end else if (len_bytes == LEN_W'(SHORT_BYTES) && !want_long) begin
            ok  = 1'b1;
            cap = CAP_SHORT;
        end
    end

endmodule

// File: rtl/sdc_rsp_bank.sv
module sdc_rsp_bank
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  cap_e             cap,
    input  logic [RSP_W-1:0] data,
    output logic [RSP_W-1:0] words
);

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (load) begin
                if (cap == CAP_LONG) begin
                    word_d = data[k*WORD_W +: WORD_W];
                end else if (cap == CAP_SHORT) begin
                    word_d = (k == 0) ? data[RSP_W-1 -: WORD_W] : '0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[k*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/sdc_cmd_issuer.sv
module sdc_cmd_issuer
    import sdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr_en,
    input  logic [CMD_W-1:0]   cmd_wr_data,
    input  logic               arg_wr_en,
    input  logic [WORD_W-1:0]  arg_wr_data,
    input  logic               sts_clr_en,
    input  logic [STS_W-1:0]   sts_clr_mask,
    input  logic               cfg_busy_irq_en,
    output logic [CMD_W-1:0]   cmd_reg,
    output logic [WORD_W-1:0]  arg_reg,
    output logic [STS_W-1:0]   host_status,
    output logic               busy,
    output logic [RSP_W-1:0]   rsp_words,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [IDX_W-1:0]   req_index,
    output logic [WORD_W-1:0]  req_arg,
    output logic               resp_ready,
    input  logic               resp_valid,
    input  logic               resp_err,
    input  logic [LEN_W-1:0]   resp_len,
    input  logic [RSP_W-1:0]   resp_data
);

    typedef struct packed {
        phase_e             phase;
        logic [CMD_W-1:0]   cmd;
        logic [WORD_W-1:0]  arg;
        logic [STS_W-1:0]   sts;
    } state_t;

    state_t      st_d, st_q;
    cmd_fields_t live;
    logic        judge_ok;
    cap_e        judge_cap;
    logic        load_rsp;

    sdc_cmd_decode u_decode (
        .cmd_word (st_q.cmd),
        .fields   (live)
    );

    sdc_resp_judge u_judge (
        .want_long (live.long_rsp),
        .want_none (live.no_rsp),
        .card_err  (resp_err),
        .len_bytes (resp_len),
        .ok        (judge_ok),
        .cap       (judge_cap)
    );

    sdc_rsp_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_rsp),
        .cap   (judge_cap),
        .data  (resp_data),
        .words (rsp_words)
    );

    always_comb begin
        st_d     = st_q;
        load_rsp = 1'b0;
        if (sts_clr_en) begin
            st_d.sts = st_q.sts & ~sts_clr_mask;
        end
        unique case (st_q.phase)
            PH_IDLE: begin
                if (arg_wr_en) begin
                    st_d.arg = arg_wr_data;
                end
                if (cmd_wr_en) begin
                    st_d.cmd = cmd_wr_data;
                    if (cmd_wr_data[CB_START]) begin
                        st_d.phase = PH_REQ;
                    end
                end
            end
            PH_REQ: begin
                if (req_ready) begin
                    st_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (resp_valid) begin
                    st_d.phase         = PH_IDLE;
                    st_d.cmd[CB_START] = 1'b0;
                    if (judge_ok) begin
                        load_rsp = 1'b1;
                        if (live.busy_wait && cfg_busy_irq_en) begin
                            st_d.sts[SB_BUSYDONE] = 1'b1;
                        end
                    end else begin
                        st_d.cmd[CB_FAIL]    = 1'b1;
                        st_d.sts[SB_TIMEOUT] = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cmd   <= '0;
            st_q.arg   <= '0;
            st_q.sts   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_reg     = st_q.cmd;
    assign arg_reg     = st_q.arg;
    assign host_status = st_q.sts;
    assign busy        = (st_q.phase != PH_IDLE);
    assign req_valid   = (st_q.phase == PH_REQ);
    assign resp_ready  = (st_q.phase == PH_WAIT);
    assign req_index   = live.index;
    assign req_arg     = st_q.arg;

endmodule

// File: rtl/sdc_cmd_issuer_chk.sv
module sdc_cmd_issuer_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_wr_en,
    input logic [15:0]  cmd_wr_data,
    input logic         arg_wr_en,
    input logic [15:0]  cmd_reg,
    input logic [31:0]  arg_reg,
    input logic [15:0]  host_status,
    input logic         busy,
    input logic [127:0] rsp_words,
    input logic         req_valid,
    input logic         req_ready,
    input logic [5:0]   req_index,
    input logic [31:0]  req_arg,
    input logic         resp_ready,
    input logic         resp_valid,
    input logic         resp_err
);

    // R2
    start_opens_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr_en && cmd_wr_data[15]) |=> (busy && req_valid && req_index == $past(cmd_wr_data[5:0])));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

    // R4
    phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, resp_ready}) && ((req_valid || resp_ready) == busy));

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready) |=> (!busy && !cmd_reg[15]));

    // R7
    card_err_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready && resp_err) |=> (cmd_reg[14] && host_status[6]));

    // R8
    no_rsp_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready && cmd_reg[10]) |=> $stable(rsp_words));

    // R11
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_wr_en || arg_wr_en) && !(resp_valid && resp_ready)) |=> ($stable(cmd_reg) && $stable(arg_reg)));

endmodule

bind sdc_cmd_issuer sdc_cmd_issuer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wr_data (cmd_wr_data),
    .arg_wr_en   (arg_wr_en),
    .cmd_reg     (cmd_reg),
    .arg_reg     (arg_reg),
    .host_status (host_status),
    .busy        (busy),
    .rsp_words   (rsp_words),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_index   (req_index),
    .req_arg     (req_arg),
    .resp_ready  (resp_ready),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err)
);

// File: tb/sdc_cmd_issuer_bench.sv
module sdc_cmd_issuer_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr_en = 1'b0;
    logic [15:0]  cmd_wr_data = '0;
    logic         arg_wr_en = 1'b0;
    logic [31:0]  arg_wr_data = '0;
    logic         sts_clr_en = 1'b0;
    logic [15:0]  sts_clr_mask = '0;
    logic         cfg_busy_irq_en = 1'b0;
    logic [15:0]  cmd_reg;
    logic [31:0]  arg_reg;
    logic [15:0]  host_status;
    logic         busy;
    logic [127:0] rsp_words;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         resp_ready;
    logic         resp_valid = 1'b0;
    logic         resp_err = 1'b0;
    logic [4:0]   resp_len = '0;
    logic [127:0] resp_data = '0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    sdc_cmd_issuer u_sdc_cmd_issuer (.*);

    // behavioural reference model
    int          m_phase;
    logic [15:0] m_cmd, m_sts;
    logic [31:0] m_arg;
    logic [31:0] m_rsp [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cmd = '0; m_sts = '0; m_arg = '0;
            foreach (m_rsp[i]) m_rsp[i] = '0;
        end else begin
            if (sts_clr_en) m_sts = m_sts & ~sts_clr_mask;
            if (m_phase == 0) begin
                if (arg_wr_en) m_arg = arg_wr_data;
                if (cmd_wr_en) begin
                    m_cmd = cmd_wr_data;
                    if (cmd_wr_data[15]) m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (req_ready) m_phase = 2;
            end else if (resp_valid) begin
                bit good;
                good = 1'b0;
                if (resp_err) good = 1'b0;
                else if (m_cmd[10]) good = 1'b1;
                else if (resp_len == 16) begin
                    good = 1'b1;
                    for (int i = 0; i < 4; i++) m_rsp[i] = resp_data[32*i +: 32];
                end else if (resp_len == 4 && !m_cmd[9]) begin
                    good = 1'b1;
                    m_rsp[0] = resp_data[127:96];
                    for (int i = 1; i < 4; i++) m_rsp[i] = '0;
                end
                if (good) begin
                    if (m_cmd[11] && cfg_busy_irq_en) m_sts[10] = 1'b1;
                end else begin
                    m_cmd[14] = 1'b1;
                    m_sts[6] = 1'b1;
                end
                m_cmd[15] = 1'b0;
                m_phase = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_phase != 0) && req_valid == (m_phase == 1) && resp_ready == (m_phase == 2),
                "R2 R4 model phase", {busy, req_valid, resp_ready}, {m_phase != 0, m_phase == 1, m_phase == 2});
            chk(cmd_reg == m_cmd && arg_reg == m_arg, "R11 model regs", {cmd_reg, arg_reg}, {m_cmd, m_arg});
            chk(host_status == m_sts, "R10 model status", host_status, m_sts);
            chk(rsp_words == {m_rsp[3], m_rsp[2], m_rsp[1], m_rsp[0]}, "R5 R6 model rsp",
                rsp_words, {m_rsp[3], m_rsp[2], m_rsp[1], m_rsp[0]});
            chk(req_index == m_cmd[5:0] && req_arg == m_arg, "R2 model request",
                {req_index, req_arg}, {m_cmd[5:0], m_arg});
        end
    end

    task automatic wr_arg(input logic [31:0] v);
        @(negedge clk); arg_wr_en = 1'b1; arg_wr_data = v;
        @(negedge clk); arg_wr_en = 1'b0;
    endtask

    task automatic wr_cmd(input logic [15:0] v);
        @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = v;
        @(negedge clk); cmd_wr_en = 1'b0;
    endtask

    task automatic serve(input logic [4:0] len, input bit err, input logic [127:0] d, input int rdy_wait);
        while (!req_valid) @(negedge clk);
        repeat (rdy_wait) @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        resp_len = len; resp_err = err; resp_data = d; resp_valid = 1'b1;
        @(negedge clk); resp_valid = 1'b0; resp_err = 1'b0;
    endtask

    task automatic run(input logic [15:0] c, input logic [4:0] len, input bit err, input logic [127:0] d);
        wr_cmd(c);
        serve(len, err, d, 1);
    endtask

    task automatic clear_all();
        @(negedge clk); sts_clr_en = 1'b1; sts_clr_mask = 16'hFFFF;
        @(negedge clk); sts_clr_en = 1'b0;
        wr_cmd(16'h0000);
    endtask

    localparam logic [127:0] PAT_A = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] PAT_B = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4;

    task automatic report();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog expired act=0 exp=1");
            report();
        end
    end

    initial begin
        logic [127:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!busy && !req_valid && !resp_ready, "R1 control low", {busy, req_valid, resp_ready}, 0);
        chk(cmd_reg == 0 && arg_reg == 0 && host_status == 0 && rsp_words == 0, "R1 regs zero",
            {cmd_reg, arg_reg, host_status}, 0);

        // R3 plain write
        wr_arg(32'hDEADBEEF);
        wr_cmd(16'h0011);
        repeat (3) @(negedge clk);
        chk(cmd_reg == 16'h0011 && !req_valid && !busy, "R3 store only", {cmd_reg, req_valid}, {16'h0011, 1'b0});

        // R2 / R5 short response
        wr_cmd(16'h8000 | 16'd17);
        chk(busy && req_valid && req_index == 6'd17 && req_arg == 32'hDEADBEEF, "R2 request fields",
            {busy, req_valid, req_index, req_arg}, {1'b1, 1'b1, 6'd17, 32'hDEADBEEF});
        serve(5'd4, 1'b0, PAT_A, 3);
        chk(rsp_words == {96'b0, 32'h00112233}, "R5 short capture", rsp_words, {96'b0, 32'h00112233});
        chk(!busy && cmd_reg[15] == 1'b0 && cmd_reg[14] == 1'b0, "R4 done clears start", cmd_reg, 16'h0011);

        // R6 long response
        run(16'h8200 | 16'd2, 5'd16, 1'b0, PAT_A);
        chk(rsp_words == PAT_A, "R6 long capture reversed", rsp_words, PAT_A);
        run(16'h8000 | 16'd9, 5'd16, 1'b0, PAT_B);
        chk(rsp_words == PAT_B, "R6 long reply to short class", rsp_words, PAT_B);

        // R7 errors
        keep = rsp_words;
        run(16'h8200 | 16'd3, 5'd4, 1'b0, PAT_A);
        chk(cmd_reg[14] && host_status[6] && rsp_words == keep, "R7 short reply to long class",
            {cmd_reg, host_status}, {16'hC203 & 16'h7FFF, 16'h0040});
        clear_all();
        run(16'h8000 | 16'd4, 5'd0, 1'b0, PAT_A);
        chk(cmd_reg[14] && host_status[6] && rsp_words == keep, "R7 zero length", {cmd_reg, host_status}, 0);
        clear_all();
        run(16'h8000 | 16'd5, 5'd8, 1'b0, PAT_A);
        chk(cmd_reg[14] && host_status[6] && rsp_words == keep, "R7 odd length", {cmd_reg, host_status}, 0);
        clear_all();
        run(16'h8000 | 16'd6, 5'd16, 1'b1, PAT_A);
        chk(cmd_reg[14] && host_status[6] && rsp_words == keep, "R7 card error", {cmd_reg, host_status}, 0);
        // R10 clear
        @(negedge clk); sts_clr_en = 1'b1; sts_clr_mask = 16'h0040;
        @(negedge clk); sts_clr_en = 1'b0;
        chk(host_status == 16'h0000, "R10 status cleared", host_status, 0);
        clear_all();

        // R8 no-response
        run(16'h8400 | 16'd7, 5'd0, 1'b0, PAT_A);
        chk(!cmd_reg[14] && host_status == 0 && rsp_words == keep, "R8 no-response keeps words",
            {cmd_reg, host_status}, {16'h0407, 16'h0});
        run(16'h8400 | 16'd7, 5'd4, 1'b1, PAT_A);
        chk(cmd_reg[14] && host_status[6] && rsp_words == keep, "R8 no-response card error", cmd_reg, 16'h4407);
        clear_all();

        // R9 busy-wait
        run(16'h8800 | 16'd12, 5'd4, 1'b0, PAT_B);
        chk(host_status[10] == 1'b0, "R9 busy bit without enable", host_status, 0);
        cfg_busy_irq_en = 1'b1;
        run(16'h8800 | 16'd12, 5'd4, 1'b0, PAT_B);
        chk(host_status == 16'h0400, "R9 busy bit with enable", host_status, 16'h0400);
        cfg_busy_irq_en = 1'b0;
        clear_all();

        // R11 writes while busy ignored
        wr_arg(32'h0000CAFE);
        wr_cmd(16'h8000 | 16'd20);
        wr_cmd(16'h8000 | 16'd33);
        wr_arg(32'h12345678);
        chk(cmd_reg == (16'h8000 | 16'd20) && req_index == 6'd20 && req_arg == 32'h0000CAFE,
            "R11 busy write ignored", {cmd_reg, req_arg}, {16'h8014, 32'h0000CAFE});
        serve(5'd4, 1'b0, PAT_B, 0);
        chk(rsp_words == {96'b0, 32'hA1A2A3A4} && !busy, "R11 original command completes",
            rsp_words, {96'b0, 32'hA1A2A3A4});

        repeat (3) @(negedge clk);
        report();
    end

endmodule